// File: doc/BRIEF.md
# Alternate-Function Select Write Guard

This block protects the per-pin alternate-function select bits of an 8-pin port. The protection has two levels. A 32-bit key opens a lock. While the lock is open, software may load a commit mask. Each bit of the commit mask then decides whether software may change the matching alternate-function bit. Once the mask is set and the lock is closed again, the chosen pins keep their alternate-function setting even if software writes to the select register by mistake.

All registers sit on a simple single-cycle register bus:

- A write takes effect at the clock edge on which `bus_wr` is high.
- Read data is a combinational function of `bus_addr`, so a read has no side effects.
- The select bits also leave the block directly on `af_sel`, to drive pad multiplexing that lies outside this block.

Register offsets:

| Offset | Register |
|--------|----------|
| 0x420 | alternate-function select |
| 0x520 | lock |
| 0x524 | commit mask |

Top module: `afg_guard`

## Requirements
- R1: After a synchronous reset, the block is locked (the lock register reads 1), the commit mask reads 0xFF, and the alternate-function select register and `af_sel` read 0.
- R2: A write of exactly 0x0ACCE551 to offset 0x520 unlocks the block. From the next cycle, the lock register reads 0.
- R3: A write of any other value to offset 0x520 locks the block, and the lock register reads 1. The block never relocks on its own: it stays unlocked through any number of other accesses.
- R4: A write to the commit mask at offset 0x524 is accepted only while the block is unlocked. A write made while locked leaves the mask unchanged.
- R5: A write to the select register at offset 0x420 changes only the bits whose commit-mask bit is 1. Bit i of the mask guards bit i of the select register. All other select bits keep their value.
- R6: The commit mask and the select register take only bits 7:0 of the written word. Every register reads back zero-extended, so bits 31:8 of read data are 0.
- R7: A select write is masked by the commit value held before that write's clock edge. A change to the commit mask therefore applies from the next access.
- R8: Reads have no side effects. An offset outside the three registers reads 0, and a write to such an offset changes no register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write strobe for the current address |
| bus_addr | input | 12 | Byte offset of the accessed register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, zero-extended |
| af_sel | output | 8 | Current alternate-function select bits |

## Verification
The select register is written with patterns of ones and zeros on both sides of the commit mask: a full mask, a low-nibble mask, and an empty mask. This separates correct per-bit gating from whole-register gating and from inverted gating. Lock writes cover three cases: the exact key, a key that differs in its lowest bit, and long runs of unrelated accesses. These tell an exact-match key from a partial compare, and show that the block does not relock on a timer. Writes carrying ones in bits 31:8, writes to unmapped offsets, and a commit change followed at once by a select write show that inputs are truncated, that address decode is exact, and that the commit value in force is the one from before the write.

// File: rtl/afg_pkg.sv
package afg_pkg;

    localparam int unsigned BUS_ADDR_W = 12;
    localparam int unsigned BUS_DATA_W = 32;
    localparam int unsigned PORT_PINS  = 8;

    localparam logic [BUS_ADDR_W-1:0] OFF_AFSEL  = 12'h420;
    localparam logic [BUS_ADDR_W-1:0] OFF_LOCK   = 12'h520;
    localparam logic [BUS_ADDR_W-1:0] OFF_COMMIT = 12'h524;

    localparam logic [BUS_DATA_W-1:0] UNLOCK_KEY = 32'h0ACC_E551;

    typedef enum logic [1:0] {
        REG_NONE,
        REG_AFSEL,
        REG_LOCK,
        REG_COMMIT
    } reg_sel_e;

    function automatic reg_sel_e decode_offset(input logic [BUS_ADDR_W-1:0] off);
        case (off)
            OFF_AFSEL:  return REG_AFSEL;
            OFF_LOCK:   return REG_LOCK;
            OFF_COMMIT: return REG_COMMIT;
            default:    return REG_NONE;
        endcase
    endfunction

endpackage

// File: rtl/afg_key_lock.sv
module afg_key_lock
    import afg_pkg::*;
#(
    parameter int unsigned DATA_W = BUS_DATA_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wdata,
    output logic              locked_o
);

    logic locked_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            locked_q <= 1'b1;
        end else if (wr_en) begin
            locked_q <= (wdata != UNLOCK_KEY);
        end
    end

    assign locked_o = locked_q;

    assert_key_opens_R2: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wdata == UNLOCK_KEY) |=> !locked_o);

    assert_other_closes_R3: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wdata != UNLOCK_KEY) |=> locked_o);

    assert_no_self_relock_R3: assert property (@(posedge clk) disable iff (rst)
        !wr_en |=> $stable(locked_o));

endmodule

// File: rtl/afg_commit_reg.sv
module afg_commit_reg
    import afg_pkg::*;
#(
    parameter int unsigned PINS = PORT_PINS
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            wr_en,
    input  logic            locked_i,
    input  logic [PINS-1:0] wdata,
    output logic [PINS-1:0] commit_o
);

    localparam logic [PINS-1:0] COMMIT_RESET = '1;

    logic [PINS-1:0] commit_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            commit_q <= COMMIT_RESET;
        end else if (wr_en && !locked_i) begin
            commit_q <= wdata;
        end
    end

    assign commit_o = commit_q;

    assert_locked_ignored_R4: assert property (@(posedge clk) disable iff (rst)
        (wr_en && locked_i) |=> $stable(commit_o));

    assert_unlocked_loads_R4: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !locked_i) |=> (commit_o == $past(wdata)));

endmodule

// File: rtl/afg_select_reg.sv
module afg_select_reg
    import afg_pkg::*;
#(
    parameter int unsigned PINS = PORT_PINS
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            wr_en,
    input  logic [PINS-1:0] commit_i,
    input  logic [PINS-1:0] wdata,
    output logic [PINS-1:0] af_o
);

    logic [PINS-1:0] af_q;

    for (genvar b = 0; b < PINS; b++) begin : g_pin
        always_ff @(posedge clk) begin
            if (rst) begin
                af_q[b] <= 1'b0;
            end else if (wr_en && commit_i[b]) begin
                af_q[b] <= wdata[b];
            end
        end
    end

    assign af_o = af_q;

    assert_guarded_bits_kept_R5: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> (((af_o ^ $past(af_o)) & ~$past(commit_i)) == '0));

    assert_open_bits_follow_R7: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> (((af_o ^ $past(wdata)) & $past(commit_i)) == '0));

    assert_idle_hold_R8: assert property (@(posedge clk) disable iff (rst)
        !wr_en |=> $stable(af_o));

endmodule

// File: rtl/afg_guard.sv
module afg_guard
    import afg_pkg::*;
#(
    parameter int unsigned ADDR_W = BUS_ADDR_W,
    parameter int unsigned DATA_W = BUS_DATA_W,
    parameter int unsigned PINS   = PORT_PINS
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic [PINS-1:0]   af_sel
);

    localparam int unsigned PAD_W = DATA_W - PINS;

    reg_sel_e        sel;
    logic            locked;
    logic [PINS-1:0] commit;
    logic [PINS-1:0] af_bits;

    assign sel = decode_offset(bus_addr);

    afg_key_lock #(.DATA_W(DATA_W)) u_lock (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (bus_wr && sel == REG_LOCK),
        .wdata    (bus_wdata),
        .locked_o (locked)
    );

    afg_commit_reg #(.PINS(PINS)) u_commit (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (bus_wr && sel == REG_COMMIT),
        .locked_i (locked),
        .wdata    (bus_wdata[PINS-1:0]),
        .commit_o (commit)
    );

    afg_select_reg #(.PINS(PINS)) u_select (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (bus_wr && sel == REG_AFSEL),
        .commit_i (commit),
        .wdata    (bus_wdata[PINS-1:0]),
        .af_o     (af_bits)
    );

    always_comb begin
        case (sel)
            REG_AFSEL:  bus_rdata = {{PAD_W{1'b0}}, af_bits};
            REG_COMMIT: bus_rdata = {{PAD_W{1'b0}}, commit};
            REG_LOCK:   bus_rdata = {{(DATA_W-1){1'b0}}, locked};
            default:    bus_rdata = '0;
        endcase
    end

    assign af_sel = af_bits;

    assert_upper_zero_R6: assert property (@(posedge clk) disable iff (rst)
        bus_rdata[DATA_W-1:PINS] == '0);

    assert_afsel_port_matches_R1: assert property (@(posedge clk) disable iff (rst)
        (sel == REG_AFSEL) |-> (bus_rdata[PINS-1:0] == af_sel));

    assert_commit_needs_unlock_R4: assert property (@(posedge clk) disable iff (rst)
        (commit != $past(commit)) |-> !$past(locked));

endmodule

// File: tb/afg_guard_bench.sv
module afg_guard_bench;

    localparam int NV = 15;

    // vector: {wr, waddr[11:0], wdata[31:0], raddr[11:0], expect[31:0], tag[15:0]}
    localparam logic [104:0] VEC [NV] = '{
        {1'b0, 12'h000, 32'h0000_0000, 12'h520, 32'h0000_0001, "R1"},
        {1'b0, 12'h000, 32'h0000_0000, 12'h524, 32'h0000_00FF, "R1"},
        {1'b0, 12'h000, 32'h0000_0000, 12'h420, 32'h0000_0000, "R1"},
        {1'b1, 12'h524, 32'h0000_0000, 12'h524, 32'h0000_00FF, "R4"},
        {1'b1, 12'h420, 32'hFFFF_FFA5, 12'h420, 32'h0000_00A5, "R6"},
        {1'b1, 12'h520, 32'h0ACC_E551, 12'h520, 32'h0000_0000, "R2"},
        {1'b1, 12'h524, 32'h1234_560F, 12'h524, 32'h0000_000F, "R6"},
        {1'b1, 12'h420, 32'h0000_005A, 12'h420, 32'h0000_00AA, "R5"},
        {1'b1, 12'h700, 32'hFFFF_FFFF, 12'h524, 32'h0000_000F, "R8"},
        {1'b0, 12'h000, 32'h0000_0000, 12'h520, 32'h0000_0000, "R3"},
        {1'b1, 12'h520, 32'h0ACC_E550, 12'h520, 32'h0000_0001, "R3"},
        {1'b1, 12'h524, 32'h0000_00FF, 12'h524, 32'h0000_000F, "R4"},
        {1'b1, 12'h420, 32'h0000_0000, 12'h420, 32'h0000_00A0, "R5"},
        {1'b0, 12'h000, 32'h0000_0000, 12'h7F0, 32'h0000_0000, "R8"},
        {1'b1, 12'h421, 32'h0000_00FF, 12'h420, 32'h0000_00A0, "R8"}
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_wr = 1'b0;
    logic [11:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [7:0]  af_sel;

    int applied = 0;
    int failed = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    afg_guard u_afg_guard (
        .clk       (clk),
        .rst       (rst),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .af_sel    (af_sel)
    );

    task automatic compare(input logic [31:0] got, input logic [31:0] exp, input string tag);
        applied++;
        if (got !== exp) begin
            failed++;
            $display("FAIL %s: got %08h expected %08h", tag, got, exp);
        end
    endtask

    task automatic write_then_read(input logic wr, input logic [11:0] wa, input logic [31:0] wd,
                                   input logic [11:0] ra, input logic [31:0] exp, input string tag);
        @(negedge clk);
        bus_wr = wr;
        bus_addr = wa;
        bus_wdata = wd;
        @(negedge clk);
        bus_wr = 1'b0;
        bus_addr = ra;
        bus_wdata = '0;
        #1;
        compare(bus_rdata, exp, tag);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;

        for (int i = 0; i < NV; i++) begin
            write_then_read(VEC[i][104], VEC[i][103:92], VEC[i][91:60],
                            VEC[i][59:48], VEC[i][47:16], string'(VEC[i][15:0]));
        end

        // R3: unlock, then many unrelated accesses; still unlocked
        write_then_read(1'b1, 12'h520, 32'h0ACC_E551, 12'h520, 32'h0, "R2");
        for (int k = 0; k < 20; k++) begin
            write_then_read(1'b0, 12'h000, 32'h0, 12'h420, 32'h0000_00A0, "R8");
        end
        write_then_read(1'b0, 12'h000, 32'h0, 12'h520, 32'h0, "R3");

        // R7: clear the mask, then an immediate select write must be blocked
        write_then_read(1'b1, 12'h524, 32'h0000_0000, 12'h524, 32'h0, "R7");
        write_then_read(1'b1, 12'h420, 32'h0000_00FF, 12'h420, 32'h0000_00A0, "R7");
        write_then_read(1'b1, 12'h524, 32'h0000_00FF, 12'h524, 32'h0000_00FF, "R7");
        write_then_read(1'b1, 12'h420, 32'h0000_000F, 12'h420, 32'h0000_000F, "R7");
        compare({24'h0, af_sel}, 32'h0000_000F, "R5");

        // R1: reset in mid-run
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        bus_addr = 12'h520;
        #1 compare(bus_rdata, 32'h1, "R1");
        bus_addr = 12'h524;
        #1 compare(bus_rdata, 32'hFF, "R1");
        bus_addr = 12'h420;
        #1 compare(bus_rdata, 32'h0, "R1");
        compare({24'h0, af_sel}, 32'h0, "R1");

        done = 1'b1;
    end

    initial begin
        int cyc = 0;
        while (!done && cyc < 20000) begin
            @(posedge clk);
            cyc++;
        end
        if (!done) begin
            failed++;
            $display("FAIL watchdog: got timeout expected completion");
        end
        $display("== %0d vectors applied, %0d miscompares ==", applied, failed);
        $finish;
    end

endmodule